// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counting Timer

This block is a memory-mapped timer peripheral. A single 16-bit prescaler, shared by every channel, divides the system clock. Each of `NUM_CH` 32-bit channels counts down once per prescaler tick. A channel fires when its count passes below zero, not when it reaches zero. When it fires, it can set a sticky pending flag and pulse its own interrupt line. It then either reloads itself and keeps running, or parks at all-ones and goes idle. Software drives the block through a single-cycle 32-bit write port and a combinational read port, both addressed by byte offset.

The unit window sits at offset 0x00. Offset 0x00 is the live prescaler value, 0x04 is the prescaler reload and 0x08 is a read-only identification word. Channel n uses the 16-byte window starting at 0x10 + 0x10*n. In that window the live count is at +0x0, the reload value at +0x4 and the control word at +0x8.

Each channel is a two-state machine. In CH_IDLE the count is frozen; in CH_RUN it decrements on each tick. The machine moves from CH_IDLE to CH_RUN on a control write with enable set, or on a counter write while enable is already set. It moves from CH_RUN to CH_IDLE on a control write that clears enable, or on an underflow while auto-restart is off. A bus write to a channel's counter or control word takes precedence over a tick arriving in the same cycle for that channel.

Top module: `tick_timer_unit`

## Requirements
- R1: Channel n's count, reload and control words are at byte offsets 0x10+0x10*n+0x0, +0x4 and +0x8. The unit's prescaler value, prescaler reload and identification word are at 0x00, 0x04 and 0x08.
- R2: Writes to the prescaler value and prescaler reload keep only bits [15:0]. Bits [31:16] read back as 0.
- R3: The prescaler counts down once per clock. While it is 0 it raises the shared tick, and at the next clock it takes the reload value. Ticks therefore repeat every (reload+1) clocks.
- R4: A running channel loaded with N fires on the (N+1)th tick after loading.
- R5: When a channel fires with interrupt enable (control bit 3) set, it sets pending (control bit 4) and drives its `irq_o` bit high for the one clock after the firing edge. With interrupt enable clear, neither happens.
- R6: If auto-restart (control bit 1) is set when a channel fires, the count takes the reload value and the channel keeps running. Otherwise the count becomes 0xFFFFFFFF and holds there.
- R7: Writing the control word with load (bit 2) set copies the reload value into the count. The channel runs if enable (bit 0) is set. Bit 2 always reads as 0.
- R8: A counter write sets the count directly, and the channel runs from that value if enable is already set.
- R9: A control write with bit 4 set clears pending; a control write with bit 4 clear leaves pending unchanged.
- R10: The identification word is read-only and equals NUM_CH in [2:0], BASE_IRQ in [7:3], 1 in bit 8 and 1 in bit 9. For the default parameters it is 0x343. All other registers reset to 0.
- R11: These offsets read as 0 and ignore writes: offsets not aligned to a word, the fourth word of any window, and channel windows with index NUM_CH or above.
- R12: The control word reads back as enable in bit 0, auto-restart in bit 1, 0 in bit 2, interrupt enable in bit 3 and pending in bit 4, with 0 above bit 4. A channel is only ever in CH_RUN while its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at this clock edge |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | NUM_CH | One-clock interrupt pulse per channel |

## Verification
If a channel's state register is wrong, the firing time moves. The scoreboard sees this at the first interrupt, because each pulse is compared against the exact clock computed from the load value and the tick spacing. A count that drifts while the channel is idle, or that fails to park at all-ones, shows on the next readback of the count word. A pending flag that is wrongly set or dropped shows on the next read of the control word. A prescaler that is off by one shifts every later firing by whole clock periods within the first restart interval.

// File: rtl/timer_unit_pkg.sv
package timer_unit_pkg;

    localparam int CTL_EN   = 0;
    localparam int CTL_RS   = 1;
    localparam int CTL_LD   = 2;
    localparam int CTL_IE   = 3;
    localparam int CTL_PEND = 4;
    localparam int CTL_W    = 5;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef enum logic [1:0] {
        RG_COUNT  = 2'd0,
        RG_RELOAD = 2'd1,
        RG_CTRL   = 2'd2,
        RG_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tu_prescaler.sv
module tu_prescaler #(
    parameter int SCALER_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_val,
    input  logic                wr_rld,
    input  logic [SCALER_W-1:0] wdata,
    output logic [SCALER_W-1:0] val_o,
    output logic [SCALER_W-1:0] rld_o,
    output logic                tick_o
);

    logic [SCALER_W-1:0] val_q;
    logic [SCALER_W-1:0] rld_q;

    assign tick_o = (val_q == '0);
    assign val_o  = val_q;
    assign rld_o  = rld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            rld_q <= '0;
        end else begin
            if (wr_rld) begin
                rld_q <= wdata;
            end
            if (wr_val) begin
                val_q <= wdata;
            end else if (tick_o) begin
                val_q <= rld_q;
            end else begin
                val_q <= val_q - SCALER_W'(1);
            end
        end
    end

    // R3: between ticks the value steps down by one per clock
    p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_val && !tick_o) |=> (val_q == $past(val_q) - SCALER_W'(1)));

    // R3: a tick is followed by the reload value
    p_wrap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_val && !wr_rld && tick_o) |=> (val_q == $past(rld_q)));

endmodule

// File: rtl/tu_addr_decode.sv
module tu_addr_decode
    import timer_unit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 3,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              unit_hit,
    output logic              ch_hit,
    output logic [IDX_W-1:0]  ch_idx,
    output reg_sel_e          reg_sel
);

    localparam int WIN_W = ADDR_W - 4;

    logic [WIN_W-1:0] win;
    logic             aligned;
    logic             reg_ok;

    assign win     = addr[ADDR_W-1:4];
    assign aligned = (addr[1:0] == 2'b00);
    assign reg_sel = reg_sel_e'(addr[3:2]);
    assign reg_ok  = (reg_sel != RG_NONE);

    assign unit_hit = aligned && reg_ok && (win == '0);
    assign ch_hit   = aligned && reg_ok && (win != '0) && (win <= WIN_W'(NUM_CH));
    assign ch_idx   = IDX_W'(win - WIN_W'(1));

    // R11: a window cannot be both the unit and a channel
    always_comb begin
        a_one_target_r11: assert (!(unit_hit && ch_hit));
    end

endmodule

// File: rtl/tu_channel.sv
module tu_channel
    import timer_unit_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_cnt,
    input  logic              wr_rld,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] rld_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              irq_o
);

    ch_state_e         state_q;
    ch_state_e         state_d;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] rld_q;
    logic              en_q;
    logic              rs_q;
    logic              ie_q;
    logic              pend_q;
    logic              irq_q;
    logic              bus_touch;
    logic              underflow;

    assign bus_touch = wr_cnt || wr_ctl;
    assign underflow = (state_q == CH_RUN) && tick && (cnt_q == '0) && !bus_touch;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (wr_ctl && wdata[CTL_EN]) begin
                    state_d = CH_RUN;
                end else if (wr_cnt && en_q) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (wr_ctl && !wdata[CTL_EN]) begin
                    state_d = CH_IDLE;
                end else if (underflow && !rs_q) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rld_q  <= '0;
            en_q   <= 1'b0;
            rs_q   <= 1'b0;
            ie_q   <= 1'b0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_rld) begin
                rld_q <= wdata;
            end

            if (wr_ctl && wdata[CTL_LD]) begin
                cnt_q <= rld_q;
            end else if (wr_cnt) begin
                cnt_q <= wdata;
            end else if (underflow) begin
                cnt_q <= rs_q ? rld_q : '1;
            end else if (state_q == CH_RUN && tick) begin
                cnt_q <= cnt_q - DATA_W'(1);
            end

            if (wr_ctl) begin
                en_q   <= wdata[CTL_EN];
                rs_q   <= wdata[CTL_RS];
                ie_q   <= wdata[CTL_IE];
                pend_q <= wdata[CTL_PEND] ? 1'b0 : pend_q;
            end else if (underflow && ie_q) begin
                pend_q <= 1'b1;
            end

            irq_q <= underflow && ie_q;
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ctl_o = {pend_q, ie_q, 1'b0, rs_q, en_q};
    assign irq_o = irq_q;

    // R5: an interrupt pulse is always accompanied by a set pending flag
    p_irq_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> pend_q);

    // R6: an idle channel with no bus access keeps its count
    p_idle_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !wr_cnt && !wr_ctl) |=> $stable(cnt_q));

    // R6: firing without restart parks the count at all-ones and idles
    p_park_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && tick && cnt_q == '0 && !wr_cnt && !wr_ctl && !rs_q)
        |=> (cnt_q == '1 && state_q == CH_IDLE));

    // R12: running implies enabled
    p_run_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> en_q);

endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
    import timer_unit_pkg::*;
#(
    parameter int NUM_CH   = 3,
    parameter int BASE_IRQ = 8,
    parameter int SCALER_W = 16,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_o
);

    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [DATA_W-1:0] UNIT_ID =
        DATA_W'({1'b1, 1'b1, 5'(BASE_IRQ), 3'(NUM_CH)});

    logic              unit_hit;
    logic              ch_hit;
    logic [IDX_W-1:0]  ch_idx;
    reg_sel_e          reg_sel;
    logic              tick;
    logic [SCALER_W-1:0] ps_val;
    logic [SCALER_W-1:0] ps_rld;

    logic [DATA_W-1:0] ch_cnt [NUM_CH];
    logic [DATA_W-1:0] ch_rld [NUM_CH];
    logic [CTL_W-1:0]  ch_ctl [NUM_CH];

    tu_addr_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .IDX_W  (IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .unit_hit (unit_hit),
        .ch_hit   (ch_hit),
        .ch_idx   (ch_idx),
        .reg_sel  (reg_sel)
    );

    tu_prescaler #(
        .SCALER_W (SCALER_W)
    ) u_prescaler (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_val (bus_wr && unit_hit && reg_sel == RG_COUNT),
        .wr_rld (bus_wr && unit_hit && reg_sel == RG_RELOAD),
        .wdata  (bus_wdata[SCALER_W-1:0]),
        .val_o  (ps_val),
        .rld_o  (ps_rld),
        .tick_o (tick)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = bus_wr && ch_hit && (ch_idx == IDX_W'(i));

        tu_channel #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .wr_cnt (sel && reg_sel == RG_COUNT),
            .wr_rld (sel && reg_sel == RG_RELOAD),
            .wr_ctl (sel && reg_sel == RG_CTRL),
            .wdata  (bus_wdata),
            .cnt_o  (ch_cnt[i]),
            .rld_o  (ch_rld[i]),
            .ctl_o  (ch_ctl[i]),
            .irq_o  (irq_o[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (unit_hit) begin
            unique case (reg_sel)
                RG_COUNT:  bus_rdata = DATA_W'(ps_val);
                RG_RELOAD: bus_rdata = DATA_W'(ps_rld);
                RG_CTRL:   bus_rdata = UNIT_ID;
                default:   bus_rdata = '0;
            endcase
        end else if (ch_hit) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_idx == IDX_W'(i)) begin
                    unique case (reg_sel)
                        RG_COUNT:  bus_rdata = ch_cnt[i];
                        RG_RELOAD: bus_rdata = ch_rld[i];
                        RG_CTRL:   bus_rdata = DATA_W'(ch_ctl[i]);
                        default:   bus_rdata = '0;
                    endcase
                end
            end
        end
    end

    // R11: anything outside the map reads as zero
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!unit_hit && !ch_hit) |-> (bus_rdata == '0));

    // R10: the identification word never changes
    p_id_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_hit && reg_sel == RG_CTRL) |-> (bus_rdata == UNIT_ID));

    // R2: prescaler readback never shows bits above the prescaler width
    p_scaler_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_hit && reg_sel != RG_CTRL) |-> (bus_rdata[DATA_W-1:SCALER_W] == '0));

endmodule

// File: tb/test_tick_timer_unit.sv
module test_tick_timer_unit;

    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq_o;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int ch;
        int at;
    } exp_irq_t;

    exp_irq_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tick_timer_unit #(.NUM_CH(NCH)) i_tick_timer_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compare every interrupt pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (irq_o[i]) begin
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R5: unexpected irq ch%0d at %0d, expected none", i, cyc);
                    end else begin
                        exp_irq_t e;
                        e = exp_q.pop_front();
                        if (e.ch != i || e.at != cyc) begin
                            n_fail++;
                            $display("FAIL R4: irq ch%0d at %0d, expected ch%0d at %0d",
                                     i, cyc, e.ch, e.at);
                        end
                    end
                end
            end
        end
    end

    // driver: called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int c);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        c = cyc;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        bus_addr = a;
        #1;
        n_checks++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s: read 0x%02h got 0x%08h expected 0x%08h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic expect_irq(input int ch, input int at);
        exp_irq_t e;
        e.ch = ch;
        e.at = at;
        exp_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
        finish_run();
    end

    initial begin
        int c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        n_checks++;
        if (irq_o !== '0) begin
            n_fail++;
            $display("FAIL R10: irq after reset 0x%0h expected 0x0", irq_o);
        end
        rd(8'h08, 32'h0000_0343, "R10");
        rd(8'h00, 32'h0, "R10");
        rd(8'h04, 32'h0, "R10");
        rd(8'h10, 32'h0, "R10");
        rd(8'h28, 32'h0, "R10");

        // r2_ prescaler masks
        wr(8'h04, 32'hFFFF_1234, c);
        rd(8'h04, 32'h0000_1234, "R2");
        wr(8'h00, 32'hABCD_0007, c);
        rd(8'h00, 32'h0000_0007, "R2");
        wr(8'h04, 32'h0, c);
        wr(8'h00, 32'h0, c);

        // R11 unmapped offsets, R10 read-only identification
        rd(8'h0C, 32'h0, "R11");
        rd(8'h40, 32'h0, "R11");
        wr(8'h44, 32'h55, c);
        rd(8'h44, 32'h0, "R11");
        rd(8'h13, 32'h0, "R11");
        wr(8'h1C, 32'h7, c);
        rd(8'h1C, 32'h0, "R11");
        rd(8'h18, 32'h0, "R11");
        wr(8'h08, 32'h0, c);
        rd(8'h08, 32'h0000_0343, "R10");

        // R4 one-shot: count 5 fires 6 ticks after enable; R6 parks at all-ones
        wr(8'h18, 32'h08, c);
        wr(8'h10, 32'd5, c);
        rd(8'h10, 32'd5, "R8");
        wr(8'h18, 32'h09, c);
        expect_irq(0, c + 6);
        repeat (8) @(negedge clk);
        rd(8'h18, 32'h19, "R12");
        rd(8'h10, 32'hFFFF_FFFF, "R6");
        repeat (5) @(negedge clk);
        rd(8'h10, 32'hFFFF_FFFF, "R6");

        // R9 pending: bit4 clear keeps, bit4 set clears
        wr(8'h18, 32'h08, c);
        rd(8'h18, 32'h18, "R9");
        wr(8'h18, 32'h18, c);
        rd(8'h18, 32'h08, "R9");

        // R7 load + R6 restart on channel 1
        wr(8'h24, 32'd3, c);
        rd(8'h24, 32'd3, "R1");
        wr(8'h28, 32'h0F, c);
        rd(8'h28, 32'h0B, "R7");
        rd(8'h20, 32'd3, "R7");
        expect_irq(1, c + 4);
        expect_irq(1, c + 8);
        expect_irq(1, c + 12);
        repeat (12) @(negedge clk);
        wr(8'h28, 32'h10, c);
        rd(8'h28, 32'h00, "R9");

        // R5 no interrupt and no pending with interrupt enable clear
        wr(8'h34, 32'd2, c);
        wr(8'h38, 32'h05, c);
        repeat (6) @(negedge clk);
        rd(8'h38, 32'h01, "R5");
        rd(8'h30, 32'hFFFF_FFFF, "R6");

        // R8 direct counter write while enabled
        wr(8'h38, 32'h09, c);
        wr(8'h30, 32'd4, c);
        expect_irq(2, c + 5);
        repeat (7) @(negedge clk);
        rd(8'h30, 32'hFFFF_FFFF, "R8");
        wr(8'h38, 32'h10, c);
        rd(8'h38, 32'h00, "R9");

        // R3 prescaler: reload 3 gives a tick every 4 clocks
        wr(8'h24, 32'd1, c);
        wr(8'h04, 32'd3, c);
        wr(8'h00, 32'd3, c);
        wr(8'h28, 32'h0F, c);
        rd(8'h00, 32'd2, "R3");
        expect_irq(1, c + 7);
        expect_irq(1, c + 15);
        repeat (15) @(negedge clk);
        wr(8'h28, 32'h10, c);
        wr(8'h04, 32'h0, c);
        wr(8'h00, 32'h0, c);

        repeat (20) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R5: %0d expected irq pulses missing, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule